// File: doc/BRIEF.md
# Field Memory Start-Up Sequencer

This block brings a reset-addressed serial field memory into a known state after power is applied. The memory has a write port and a read port. Each port has its own clock, enable and pointer-reset line. The pointers hold arbitrary values at power-up. They become valid only after a run of dummy clock cycles and a pointer reset on each port. The sequencer produces that traffic. It emits a per-port clock-enable strobe, which the clocking logic turns into one memory clock pulse, together with the port's enable and reset levels for that same pulse.

Once `supply_good` is seen, the sequencer waits a programmable number of reference-clock cycles to cover the supply stabilization time. It then releases both ports together. Each port runs its own counter in its own clock domain. It issues the minimum count of dummy cycles with the enable high and closes with a one-cycle pointer reset. If the `stable_early` strap is low, the supply may not have settled when the dummy cycles began. In that case each port uses a longer bracket: a pointer reset, then the dummy cycles, then a second pointer reset.

After the final reset, each port gives a short run of quiet clocks with reset and enable low, and then raises its done flag. The two done flags are synchronized into the reference domain. `init_done` rises only when both have arrived. `init_busy` is high from the start of the wait until `init_done` rises, so that external write and read traffic can be gated off. Loss of `supply_good` at any time returns everything to idle, and the whole sequence starts again when the supply returns.

Top module: `fmi_init_seq`

## Requirements
- R1: While `rst_n` is low, and directly after it is released with `supply_good` low, all eight outputs are 0.
- R2: After `supply_good` rises, no port strobe appears for at least STAB_CYCLES reference cycles. `init_busy` is 1 and `init_done` is 0 throughout that wait.
- R3: With the strap latched high (short mode), each port gives exactly DUMMY_MIN strobes with its enable 1 and its reset 0. It then gives exactly one strobe with its reset 1 and its enable 0.
- R4: With the strap latched low (long mode), each port gives one reset strobe, then exactly DUMMY_MIN enabled strobes, then a second reset strobe. No enabled strobe comes before the first reset.
- R5: A reset pulse lasts one strobe. After each reset the line stays 0 for at least RST_GAP strobes. After the final reset, exactly RST_GAP strobes follow with enable 0 and reset 0 before the port reports done.
- R6: The write port and the read port run their sequences at the same time, each from its own clock.
- R7: `init_done` rises only after both ports have finished. When it rises, `init_busy` falls in the same cycle. While `init_done` is 1, neither port strobes.
- R8: If `supply_good` stays 0 for three reference cycles, `init_done` and `init_busy` are 0 and all port outputs fall to 0. When the supply returns, a fresh complete sequence runs.
- R9: The strap is sampled once, when the sequencer leaves idle. Changes to the strap later in the sequence have no effect on the chosen mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock that times the stabilization wait |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| supply_good | input | 1 | Asynchronous supply-in-range indication |
| stable_early | input | 1 | Static strap: 1 = supply settled before the sequence, 0 = use the long bracket |
| wr_clk | input | 1 | Write-port clock |
| rd_clk | input | 1 | Read-port clock |
| wr_clk_en | output | 1 | Write-port clock strobe for this cycle |
| wr_en | output | 1 | Write enable level for the strobed cycle |
| wr_rst | output | 1 | Write pointer reset level for the strobed cycle |
| rd_clk_en | output | 1 | Read-port clock strobe for this cycle |
| rd_en | output | 1 | Read enable level for the strobed cycle |
| rd_rst | output | 1 | Read pointer reset level for the strobed cycle |
| init_busy | output | 1 | Sequence in progress; hold off external traffic |
| init_done | output | 1 | Memory pointers initialized; memory may be used |

## Verification
Each output is a decode of registered state. A change on `supply_good` takes two reference edges to reach the controller and one more to change its state. A change in that state then takes two port-clock edges to reach a port sequencer and one more to move it. A port's done flag returns through a further two reference edges before `init_done` can rise one edge later. The bench mirrors these latencies in a behavioural model and compares all eight outputs half a clock after every edge. Independent counters tally strobes, resets and gaps per scenario, and those totals are checked against the counts that the requirements fix.

// File: rtl/fmi_pkg.sv
package fmi_pkg;

  typedef enum logic [1:0] {
    RS_IDLE,
    RS_WAIT,
    RS_RUN,
    RS_DONE
  } ref_state_e;

  typedef enum logic [2:0] {
    PS_IDLE,
    PS_OPEN,
    PS_DUMMY,
    PS_CLOSE,
    PS_SETTLE,
    PS_DONE
  } port_state_e;

  typedef struct packed {
    logic clk_en;
    logic en;
    logic rst;
    logic done;
  } port_drive_t;

  localparam int unsigned NUM_PORTS = 2;
  localparam int unsigned WR_IDX    = 0;
  localparam int unsigned RD_IDX    = 1;

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fmi_sync.sv
module fmi_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-2:0], d};
  end

  assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/fmi_ref_ctrl.sv
module fmi_ref_ctrl
  import fmi_pkg::*;
#(
  parameter int unsigned STAB_CYCLES = 12500
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 supply_ok,
  input  logic                 stable_early,
  input  logic [NUM_PORTS-1:0] port_done,
  output logic                 start,
  output logic                 long_mode,
  output logic                 busy,
  output logic                 done
);

  localparam int unsigned CW = (STAB_CYCLES > 1) ? $clog2(STAB_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(STAB_CYCLES - 1);

  ref_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          long_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RS_IDLE;
      cnt_q   <= '0;
      long_q  <= 1'b0;
    end else if (!supply_ok) begin
      state_q <= RS_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        RS_IDLE: begin
          state_q <= RS_WAIT;
          cnt_q   <= '0;
          long_q  <= ~stable_early;
        end
        RS_WAIT: begin
          if (cnt_q == LAST) state_q <= RS_RUN;
          else               cnt_q   <= cnt_q + 1'b1;
        end
        RS_RUN: begin
          if (&port_done) state_q <= RS_DONE;
        end
        RS_DONE: state_q <= RS_DONE;
        default: state_q <= RS_IDLE;
      endcase
    end
  end

  assign start     = (state_q == RS_RUN) || (state_q == RS_DONE);
  assign long_mode = long_q;
  assign busy      = (state_q == RS_WAIT) || (state_q == RS_RUN);
  assign done      = (state_q == RS_DONE);

endmodule

// File: rtl/fmi_port_seq.sv
module fmi_port_seq
  import fmi_pkg::*;
#(
  parameter int unsigned DUMMY_MIN  = 130,
  parameter int unsigned SETTLE_CYC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        long_mode,
  output port_drive_t drv
);

  localparam int unsigned CMAX = max_u(DUMMY_MIN, SETTLE_CYC);
  localparam int unsigned CW   = (CMAX > 1) ? $clog2(CMAX) : 1;
  localparam logic [CW-1:0] DUMMY_LAST  = CW'(DUMMY_MIN - 1);
  localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYC - 1);

  port_state_e   state_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_IDLE;
      cnt_q   <= '0;
    end else if (!start) begin
      state_q <= PS_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        PS_IDLE: begin
          state_q <= long_mode ? PS_OPEN : PS_DUMMY;
          cnt_q   <= '0;
        end
        PS_OPEN: begin
          state_q <= PS_DUMMY;
          cnt_q   <= '0;
        end
        PS_DUMMY: begin
          if (cnt_q == DUMMY_LAST) state_q <= PS_CLOSE;
          else                     cnt_q   <= cnt_q + 1'b1;
        end
        PS_CLOSE: begin
          state_q <= PS_SETTLE;
          cnt_q   <= '0;
        end
        PS_SETTLE: begin
          if (cnt_q == SETTLE_LAST) state_q <= PS_DONE;
          else                      cnt_q   <= cnt_q + 1'b1;
        end
        PS_DONE: state_q <= PS_DONE;
        default: state_q <= PS_IDLE;
      endcase
    end
  end

  always_comb begin
    drv        = '0;
    drv.clk_en = (state_q == PS_OPEN) || (state_q == PS_DUMMY) ||
                 (state_q == PS_CLOSE) || (state_q == PS_SETTLE);
    drv.en     = (state_q == PS_DUMMY);
    drv.rst    = (state_q == PS_OPEN) || (state_q == PS_CLOSE);
    drv.done   = (state_q == PS_DONE);
  end

endmodule

// File: rtl/fmi_init_seq.sv
module fmi_init_seq
  import fmi_pkg::*;
#(
  parameter int unsigned STAB_CYCLES = 12500,
  parameter int unsigned DUMMY_MIN   = 130,
  parameter int unsigned RST_GAP     = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_ref,
  input  logic rst_n,
  input  logic supply_good,
  input  logic stable_early,
  input  logic wr_clk,
  input  logic rd_clk,
  output logic wr_clk_en,
  output logic wr_en,
  output logic wr_rst,
  output logic rd_clk_en,
  output logic rd_en,
  output logic rd_rst,
  output logic init_busy,
  output logic init_done
);

  logic                 supply_s;
  logic                 start;
  logic                 long_mode;
  logic [NUM_PORTS-1:0] port_clk;
  logic [NUM_PORTS-1:0] done_s;
  port_drive_t          drv [NUM_PORTS];

  assign port_clk[WR_IDX] = wr_clk;
  assign port_clk[RD_IDX] = rd_clk;

  fmi_sync #(.STAGES(SYNC_STAGES)) u_supply_sync (
    .clk   (clk_ref),
    .rst_n (rst_n),
    .d     (supply_good),
    .q     (supply_s)
  );

  fmi_ref_ctrl #(.STAB_CYCLES(STAB_CYCLES)) u_ref (
    .clk          (clk_ref),
    .rst_n        (rst_n),
    .supply_ok    (supply_s),
    .stable_early (stable_early),
    .port_done    (done_s),
    .start        (start),
    .long_mode    (long_mode),
    .busy         (init_busy),
    .done         (init_done)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic start_p;
    logic long_p;

    fmi_sync #(.STAGES(SYNC_STAGES)) u_start_sync (
      .clk (port_clk[p]), .rst_n (rst_n), .d (start), .q (start_p)
    );

    fmi_sync #(.STAGES(SYNC_STAGES)) u_long_sync (
      .clk (port_clk[p]), .rst_n (rst_n), .d (long_mode), .q (long_p)
    );

    fmi_port_seq #(
      .DUMMY_MIN  (DUMMY_MIN),
      .SETTLE_CYC (RST_GAP)
    ) u_seq (
      .clk       (port_clk[p]),
      .rst_n     (rst_n),
      .start     (start_p),
      .long_mode (long_p),
      .drv       (drv[p])
    );

    fmi_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
      .clk (clk_ref), .rst_n (rst_n), .d (drv[p].done), .q (done_s[p])
    );
  end

  assign wr_clk_en = drv[WR_IDX].clk_en;
  assign wr_en     = drv[WR_IDX].en;
  assign wr_rst    = drv[WR_IDX].rst;
  assign rd_clk_en = drv[RD_IDX].clk_en;
  assign rd_en     = drv[RD_IDX].en;
  assign rd_rst    = drv[RD_IDX].rst;

endmodule

// File: rtl/fmi_init_chk.sv
module fmi_init_chk (
  input logic clk_ref,
  input logic rst_n,
  input logic supply_good,
  input logic wr_clk,
  input logic rd_clk,
  input logic wr_clk_en,
  input logic wr_en,
  input logic wr_rst,
  input logic rd_clk_en,
  input logic rd_en,
  input logic rd_rst,
  input logic init_busy,
  input logic init_done
);

  logic [2:0] ref_cyc_q;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n)                 ref_cyc_q <= '0;
    else if (ref_cyc_q != 3'd7) ref_cyc_q <= ref_cyc_q + 1'b1;
  end

  // R3
  wr_rst_alone_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    wr_rst |-> (wr_clk_en && !wr_en));

  // R3
  rd_rst_alone_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    rd_rst |-> (rd_clk_en && !rd_en));

  // R3
  wr_en_strobed_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    wr_en |-> wr_clk_en);

  // R5
  wr_rst_gap_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    wr_rst |=> !wr_rst ##1 !wr_rst);

  // R5
  rd_rst_gap_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    rd_rst |=> !rd_rst ##1 !rd_rst);

  // R7
  done_from_busy_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(init_done) |-> ($past(init_busy) && !init_busy));

  // R7
  done_ports_quiet_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    init_done |-> (!wr_clk_en && !rd_clk_en));

  // R8
  supply_loss_idle_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (ref_cyc_q >= 3'd4 && !supply_good && !$past(supply_good) &&
     !$past(supply_good, 2) && !$past(supply_good, 3))
    |-> (!init_done && !init_busy));

endmodule

bind fmi_init_seq fmi_init_chk u_chk (
  .clk_ref     (clk_ref),
  .rst_n       (rst_n),
  .supply_good (supply_good),
  .wr_clk      (wr_clk),
  .rd_clk      (rd_clk),
  .wr_clk_en   (wr_clk_en),
  .wr_en       (wr_en),
  .wr_rst      (wr_rst),
  .rd_clk_en   (rd_clk_en),
  .rd_en       (rd_en),
  .rd_rst      (rd_rst),
  .init_busy   (init_busy),
  .init_done   (init_done)
);

// File: tb/fmi_init_seq_tb.sv
module fmi_init_seq_tb_top;

  localparam int S = 40;
  localparam int D = 130;
  localparam int G = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_good = 1'b0;
  logic stable_early = 1'b1;
  logic wr_clk_en, wr_en, wr_rst, rd_clk_en, rd_en, rd_rst;
  logic init_busy, init_done;

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  fmi_init_seq #(
    .STAB_CYCLES (S),
    .DUMMY_MIN   (D),
    .RST_GAP     (G),
    .SYNC_STAGES (2)
  ) dut_i (
    .clk_ref      (clk),
    .rst_n        (rst_n),
    .supply_good  (supply_good),
    .stable_early (stable_early),
    .wr_clk       (clk),
    .rd_clk       (clk),
    .wr_clk_en    (wr_clk_en),
    .wr_en        (wr_en),
    .wr_rst       (wr_rst),
    .rd_clk_en    (rd_clk_en),
    .rd_en        (rd_en),
    .rd_rst       (rd_rst),
    .init_busy    (init_busy),
    .init_done    (init_done)
  );

  // Behavioural reference: sync pipes as small arrays, phases as integers.
  bit m_sg[2];
  bit m_st[2];
  bit m_lg[2];
  bit m_dn[2];
  int m_rs, m_rc, m_ps, m_pc;
  bit m_long;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sg <= '{0, 0}; m_st <= '{0, 0}; m_lg <= '{0, 0}; m_dn <= '{0, 0};
      m_rs <= 0; m_rc <= 0; m_ps <= 0; m_pc <= 0; m_long <= 0;
    end else begin
      m_sg[0] <= supply_good; m_sg[1] <= m_sg[0];
      m_st[0] <= (m_rs >= 2); m_st[1] <= m_st[0];
      m_lg[0] <= m_long;      m_lg[1] <= m_lg[0];
      m_dn[0] <= (m_ps == 5); m_dn[1] <= m_dn[0];
      if (!m_sg[1]) begin
        m_rs <= 0; m_rc <= 0;
      end else if (m_rs == 0) begin
        m_rs <= 1; m_rc <= 0; m_long <= !stable_early;
      end else if (m_rs == 1) begin
        if (m_rc == S - 1) m_rs <= 2; else m_rc <= m_rc + 1;
      end else if (m_rs == 2) begin
        if (m_dn[1]) m_rs <= 3;
      end
      if (!m_st[1]) begin
        m_ps <= 0; m_pc <= 0;
      end else case (m_ps)
        0: begin m_ps <= m_lg[1] ? 1 : 2; m_pc <= 0; end
        1: begin m_ps <= 2; m_pc <= 0; end
        2: if (m_pc == D - 1) m_ps <= 3; else m_pc <= m_pc + 1;
        3: begin m_ps <= 4; m_pc <= 0; end
        4: if (m_pc == G - 1) m_ps <= 5; else m_pc <= m_pc + 1;
        default: m_ps <= 5;
      endcase
    end
  end

  function automatic bit [3:0] exp_port();
    return {(m_ps >= 1 && m_ps <= 4), (m_ps == 2), (m_ps == 1 || m_ps == 3), 1'b0};
  endfunction

  // Per-scenario tallies per port (0 write, 1 read)
  int n_en[2], n_rst[2], en_pre_rst[2], gap[2], min_gap[2], post_quiet[2];
  bit seen_rst[2];

  task automatic clear_tallies();
    for (int p = 0; p < 2; p++) begin
      n_en[p] = 0; n_rst[p] = 0; en_pre_rst[p] = 0; gap[p] = 0;
      min_gap[p] = 1000; post_quiet[p] = 0; seen_rst[p] = 0;
    end
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    bit [3:0] e;
    bit [2:0] o[2];
    if (rst_n) begin
      cyc++;
      e = exp_port();
      o[0] = {wr_clk_en, wr_en, wr_rst};
      o[1] = {rd_clk_en, rd_en, rd_rst};
      // R6: both ports follow the model each clock
      chk(o[0] == e[3:1], "R6 write port", int'(o[0]), int'(e[3:1]));
      chk(o[1] == e[3:1], "R6 read port", int'(o[1]), int'(e[3:1]));
      // R7: init flags follow the model each clock
      chk({init_busy, init_done} == {(m_rs == 1 || m_rs == 2), (m_rs == 3)},
          "R7 init flags", int'({init_busy, init_done}),
          int'({(m_rs == 1 || m_rs == 2), (m_rs == 3)}));
      for (int p = 0; p < 2; p++) begin
        if (o[p][2] && o[p][1]) begin
          n_en[p]++;
          if (!seen_rst[p]) en_pre_rst[p]++;
        end
        if (o[p][2] && o[p][0]) begin
          if (seen_rst[p] && gap[p] < min_gap[p]) min_gap[p] = gap[p];
          n_rst[p]++; seen_rst[p] = 1; gap[p] = 0; post_quiet[p] = 0;
        end else if (o[p][2]) begin
          gap[p]++;
          if (!o[p][1]) post_quiet[p]++;
        end
      end
    end
  end

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_done();
    int k;
    k = 0;
    while (!init_done && k < 2000) begin
      @(negedge clk); k++;
    end
    chk(init_done, "R7 init_done within bound", int'(init_done), 1);
  endtask

  task automatic check_ports_idle(input string tag);
    chk({wr_clk_en, wr_en, wr_rst, rd_clk_en, rd_en, rd_rst, init_busy, init_done} == 8'd0,
        tag, int'({wr_clk_en, wr_en, wr_rst, rd_clk_en, rd_en, rd_rst, init_busy, init_done}), 0);
  endtask

  initial begin : watchdog
    wait (cyc > 150000);
    n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : stim
    int strobes;
    clear_tallies();
    wait_cycles(4);
    // R1: outputs quiet under reset
    check_ports_idle("R1 during reset");
    @(negedge clk); rst_n = 1'b1;
    wait_cycles(3);
    check_ports_idle("R1 after reset release");

    // Short mode
    clear_tallies();
    stable_early = 1'b1; supply_good = 1'b1;
    strobes = 0;
    for (int i = 0; i < S + 3; i++) begin
      @(negedge clk);
      if (wr_clk_en || rd_clk_en) strobes++;
    end
    // R2: no strobe during stabilization wait, busy held
    chk(strobes == 0, "R2 no strobe during wait", strobes, 0);
    chk(init_busy && !init_done, "R2 busy during wait", int'({init_busy, init_done}), 2);
    wait_done();
    for (int p = 0; p < 2; p++) begin
      // R3: short-mode counts
      chk(en_pre_rst[p] == D, "R3 dummies before reset", en_pre_rst[p], D);
      chk(n_rst[p] == 1, "R3 single reset", n_rst[p], 1);
      // R5: settle strobes after final reset
      chk(post_quiet[p] == G, "R5 settle strobes", post_quiet[p], G);
    end
    chk(!init_busy, "R7 busy low at done", int'(init_busy), 0);
    wait_cycles(10);
    chk(init_done && !wr_clk_en && !rd_clk_en, "R7 quiet while done",
        int'({init_done, wr_clk_en, rd_clk_en}), 4);

    // R8: supply loss after completion
    supply_good = 1'b0;
    wait_cycles(8);
    check_ports_idle("R8 idle after supply loss");

    // Long mode; strap flips after sampling (R9)
    clear_tallies();
    stable_early = 1'b0; supply_good = 1'b1;
    wait_cycles(10);
    stable_early = 1'b1;
    wait_done();
    for (int p = 0; p < 2; p++) begin
      // R4 and R9: long bracket kept despite strap change
      chk(n_rst[p] == 2, "R4 R9 two resets", n_rst[p], 2);
      chk(en_pre_rst[p] == 0, "R4 nothing before first reset", en_pre_rst[p], 0);
      chk(n_en[p] == D, "R4 dummies between resets", n_en[p], D);
      // R5: gap between resets
      chk(min_gap[p] >= G, "R5 reset gap", min_gap[p], G);
      chk(post_quiet[p] == G, "R5 settle strobes long", post_quiet[p], G);
    end

    // R8: supply loss in the middle of the dummy run, then restart
    supply_good = 1'b0;
    wait_cycles(8);
    clear_tallies();
    stable_early = 1'b1; supply_good = 1'b1;
    while (n_en[0] < 50) @(negedge clk);
    supply_good = 1'b0;
    wait_cycles(8);
    check_ports_idle("R8 idle after mid-run loss");
    clear_tallies();
    supply_good = 1'b1;
    wait_done();
    for (int p = 0; p < 2; p++) begin
      chk(n_en[p] == D, "R8 full rerun dummies", n_en[p], D);
      chk(n_rst[p] == 1, "R8 full rerun reset", n_rst[p], 1);
    end
    wait_cycles(5);

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule